// File: doc/BRIEF.md
# Stopwatch Timing Core

This core measures elapsed time for sports events. It counts in BCD with a resolution of one hundredth of a second and covers a full 24-hour day. A single push-button starts and stops the watch. Counting follows a one-cycle 100 Hz tick from the clock divider. An active-low clear returns the watch to zero and stops it.

The time is held as eight BCD digits on one 32-bit port. From lowest to highest, the digits are hundredths, tenths, seconds, minutes and hours. The same digits also drive an 8-digit multiplexed seven-segment display. A free-running select advances one digit per clock, and the segment pattern for the selected digit comes out of a register in the same cycle. The stage moduli are parameters, so a bench or a fast-test build can shorten the chain. The defaults give 100/60/60/24.

Top module: `stopwatch_core`

## Requirements
- R1: While the watch runs, each clock cycle with `tick_100hz` high advances the time by one count. The nibble layout of `time_bcd` is: [3:0] hundredths, [7:4] tenths, [11:8] seconds units, [15:12] seconds tens, [19:16] minutes units, [23:20] minutes tens, [27:24] hours units, [31:28] hours tens.
- R2: Each two-digit stage wraps to 00 at its modulus and carries one count into the next stage in the same edge. The default moduli are 100, 60 and 60 below the hours stage, so 00:00:59.99 is followed by 00:01:00.00.
- R3: The hours stage counts modulo 24. Hours units wrap from 9 to 0 while the hours tens digit is 0 or 1, and from 3 to 0 when it is 2. The count after the last value of the day is all zeros.
- R4: While the watch is stopped, ticks have no effect and `time_bcd` holds its value.
- R5: The raw button passes through two synchronizing flops and a rising-edge detector. Each press toggles the run flag exactly once, however long the button is held. The toggle lands within four clock edges of the button rising.
- R6: A clock edge with `clr_n` low sets every digit to 0, stops the watch, sets `dig_sel` to 0 and sets `seg` to the pattern for 0. This holds even when a tick arrives in the same cycle.
- R7: A press that begins while `clr_n` is low and is still held after `clr_n` goes high does not start the watch.
- R8: After clear, `dig_sel` increments by one every clock, modulo 8. Select value k names nibble k of `time_bcd`.
- R9: `seg` is a registered active-high pattern with segment a in bit 0 and segment g in bit 6. It always shows the digit named by the `dig_sel` value of the same cycle. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Codes above 9 give 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous active-low clear |
| tick_100hz | input | 1 | One-cycle count strobe, nominally 100 Hz |
| btn_raw | input | 1 | Unsynchronized start/stop button, high when pressed |
| time_bcd | output | 32 | Eight BCD digits of elapsed time |
| dig_sel | output | 3 | Display digit select |
| seg | output | 7 | Seven-segment pattern, bit 0 = segment a |

## Verification
A clear and a counting tick can fall on the same clock edge, and then the clear must win outright. The bench lets the watch run up to a non-zero time. It then lowers `clr_n` and raises `tick_100hz` in the same cycle. The result is judged one edge later: all eight digits must read zero, and a follow-up burst of ticks must leave them at zero, which shows the run flag was also dropped. A second build with short lower stages drives the hours chain through 19→20 and the end-of-day wrap.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int NSTAGE = 4;
  localparam int NDIG   = 2 * NSTAGE;
  localparam int TIME_W = 4 * NDIG;
  localparam int SEL_W  = $clog2(NDIG);
  localparam int SEG_W  = 7;

  typedef logic [3:0]       bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // active-high, bit 0 = segment a ... bit 6 = segment g
  function automatic seg_t seg_of(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sw_press_edge.sv
module sw_press_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic btn_i,
  output logic press_o
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;

  // no clear on these flops: a button held through clear leaves no edge behind
  always_ff @(posedge clk) begin
    sh_q   <= {sh_q[SYNC_STAGES-2:0], btn_i};
    prev_q <= sh_q[SYNC_STAGES-1];
  end

  assign press_o = sh_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/sw_bcd_pair.sv
module sw_bcd_pair #(
  parameter int MOD = 60
) (
  input  logic        clk,
  input  logic        clr_n,
  input  logic        en_i,
  output sw_pkg::bcd_t units_o,
  output sw_pkg::bcd_t tens_o,
  output logic        carry_o
);
  localparam int TOP_T = (MOD - 1) / 10;
  localparam int TOP_U = (MOD - 1) % 10;

  sw_pkg::bcd_t u_q, t_q;
  logic         at_top;

  assign at_top  = (u_q == 4'(TOP_U)) && (t_q == 4'(TOP_T));
  assign carry_o = en_i & at_top;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      u_q <= '0;
      t_q <= '0;
    end else if (en_i) begin
      if (at_top) begin
        u_q <= '0;
        t_q <= '0;
      end else if (u_q == 4'd9) begin
        u_q <= '0;
        t_q <= t_q + 4'd1;
      end else begin
        u_q <= u_q + 4'd1;
      end
    end
  end

  assign units_o = u_q;
  assign tens_o  = t_q;
endmodule

// File: rtl/sw_scan.sv
module sw_scan (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic [sw_pkg::TIME_W-1:0] digits_i,
  output logic [sw_pkg::SEL_W-1:0]  sel_o,
  output sw_pkg::seg_t              seg_o
);
  logic [sw_pkg::SEL_W-1:0] sel_q, nxt;
  sw_pkg::seg_t             seg_q;
  sw_pkg::bcd_t             pick;

  assign nxt  = sel_q + 1'b1;
  assign pick = digits_i[4*int'(nxt) +: 4];

  // segment pattern looks one step ahead so it lines up with the new select
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      sel_q <= '0;
      seg_q <= sw_pkg::seg_of(4'd0);
    end else begin
      sel_q <= nxt;
      seg_q <= sw_pkg::seg_of(pick);
    end
  end

  assign sel_o = sel_q;
  assign seg_o = seg_q;
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core #(
  parameter int HUND_MOD    = 100,
  parameter int SEC_MOD     = 60,
  parameter int MIN_MOD     = 60,
  parameter int HOUR_MOD    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      tick_100hz,
  input  logic                      btn_raw,
  output logic [sw_pkg::TIME_W-1:0] time_bcd,
  output logic [sw_pkg::SEL_W-1:0]  dig_sel,
  output logic [sw_pkg::SEG_W-1:0]  seg
);
  localparam int NST = sw_pkg::NSTAGE;

  function automatic int stage_mod(input int i);
    case (i)
      0:       return HUND_MOD;
      1:       return SEC_MOD;
      2:       return MIN_MOD;
      default: return HOUR_MOD;
    endcase
  endfunction

  logic           press;
  logic           run_q;
  logic [NST:0]   en;
  logic           day_wrap;

  sw_press_edge #(.SYNC_STAGES(SYNC_STAGES)) u_press (
    .clk     (clk),
    .btn_i   (btn_raw),
    .press_o (press)
  );

  always_ff @(posedge clk) begin
    if (!clr_n)     run_q <= 1'b0;
    else if (press) run_q <= ~run_q;
  end

  // synchronous count enable instead of a gated clock
  assign en[0] = run_q & tick_100hz;

  for (genvar i = 0; i < NST; i++) begin : g_stage
    sw_bcd_pair #(.MOD(stage_mod(i))) u_pair (
      .clk     (clk),
      .clr_n   (clr_n),
      .en_i    (en[i]),
      .units_o (time_bcd[8*i +: 4]),
      .tens_o  (time_bcd[8*i+4 +: 4]),
      .carry_o (en[i+1])
    );
  end

  assign day_wrap = en[NST];

  sw_scan u_scan (
    .clk      (clk),
    .clr_n    (clr_n),
    .digits_i (time_bcd),
    .sel_o    (dig_sel),
    .seg_o    (seg)
  );
endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk #(
  parameter int HUND_MOD = 100,
  parameter int SEC_MOD  = 60,
  parameter int MIN_MOD  = 60,
  parameter int HOUR_MOD = 24
) (
  input logic                      clk,
  input logic                      clr_n,
  input logic                      tick,
  input logic [sw_pkg::TIME_W-1:0] time_bcd,
  input logic [sw_pkg::SEL_W-1:0]  dig_sel,
  input logic                      press,
  input logic                      run,
  input logic                      day_wrap
);
  function automatic bit digits_ok(input logic [sw_pkg::TIME_W-1:0] t);
    bit ok = 1'b1;
    int mods[4] = '{HUND_MOD, SEC_MOD, MIN_MOD, HOUR_MOD};
    for (int i = 0; i < sw_pkg::NSTAGE; i++) begin
      if (t[8*i +: 4] > 4'd9 || t[8*i+4 +: 4] > 4'd9) ok = 1'b0;
      else if (int'(t[8*i+4 +: 4]) * 10 + int'(t[8*i +: 4]) >= mods[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // R6
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |=> (time_bcd == '0 && dig_sel == '0 && !run));

  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !tick |=> $stable(time_bcd));

  // R5
  press_toggle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    press |=> (run != $past(run)));

  // R5
  press_single_chk: assert property (@(posedge clk) disable iff (!clr_n)
    press |=> !press);

  // R3
  day_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    day_wrap |=> (time_bcd == '0));

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
    digits_ok(time_bcd));

  // R8
  scan_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> (dig_sel == sw_pkg::SEL_W'($past(dig_sel) + 1'b1)));
endmodule

bind stopwatch_core stopwatch_core_chk #(
  .HUND_MOD (HUND_MOD),
  .SEC_MOD  (SEC_MOD),
  .MIN_MOD  (MIN_MOD),
  .HOUR_MOD (HOUR_MOD)
) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .tick     (tick_100hz),
  .time_bcd (time_bcd),
  .dig_sel  (dig_sel),
  .press    (press),
  .run      (run_q),
  .day_wrap (day_wrap)
);

// File: tb/stopwatch_core_bench.sv
module stopwatch_core_bench;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0, tick = 1'b0, btn = 1'b0;
  logic        clr2_n = 1'b0, tick2 = 1'b0, btn2 = 1'b0;
  logic [31:0] tm, tm2;
  logic [2:0]  sel, sel2;
  logic [6:0]  seg, seg2;
  int          tests = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  stopwatch_core u_stopwatch_core (
    .clk(clk), .clr_n(clr_n), .tick_100hz(tick), .btn_raw(btn),
    .time_bcd(tm), .dig_sel(sel), .seg(seg));

  stopwatch_core #(.HUND_MOD(10), .SEC_MOD(6), .MIN_MOD(60), .HOUR_MOD(24)) u_stopwatch_core_fast (
    .clk(clk), .clr_n(clr2_n), .tick_100hz(tick2), .btn_raw(btn2),
    .time_bcd(tm2), .dig_sel(sel2), .seg(seg2));

  function automatic logic [31:0] model(input int n, input int hm, input int sm, input int mm, input int hr);
    int c, s, m, h;
    n = n % (hm * sm * mm * hr);
    c = n % hm; n = n / hm;
    s = n % sm; n = n / sm;
    m = n % mm; h = n / mm;
    return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10), 4'(c/10), 4'(c%10)};
  endfunction

  function automatic logic [6:0] dec(input logic [3:0] d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (d > 4'd9) ? 7'h00 : t[d];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks2(input int n);
    tick2 = 1'b1;
    repeat (n) @(negedge clk);
    tick2 = 1'b0;
  endtask

  task automatic press(input int len);
    btn = 1'b1;
    repeat (len) @(negedge clk);
    btn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R6 time zero in clear", tm, 32'h0);
    chk("R6 select zero in clear", 32'(sel), 32'h0);
    chk("R6 segment shows 0 in clear", 32'(seg), 32'h3F);
    clr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_hold_idle();
    ticks(20);
    chk("R4 ticks ignored before start", tm, 32'h0);
  endtask

  task automatic t_start_long_press();
    press(12);
    ticks(37);
    chk("R1 R5 long press starts once, 37 ticks", tm, model(37, 100, 60, 60, 24));
  endtask

  task automatic t_seconds_carry();
    ticks(5999 - 37);
    chk("R2 at 00:00:59.99", tm, 32'h0000_5999);
    ticks(1);
    chk("R2 carry to 00:01:00.00", tm, 32'h0001_0000);
    ticks(123);
    chk("R1 continues counting", tm, model(6123, 100, 60, 60, 24));
  endtask

  task automatic t_stop_hold();
    logic [31:0] snap;
    press(3);
    snap = tm;
    ticks(50);
    chk("R4 stopped watch holds", tm, snap);
  endtask

  task automatic t_display();
    logic [2:0] prev;
    prev = sel;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 select steps by one", 32'(sel), 32'(3'(prev + 3'd1)));
      chk("R9 segment matches selected digit", 32'(seg), 32'(dec(tm[4*sel +: 4])));
      prev = sel;
    end
  endtask

  task automatic t_clear_with_tick();
    press(3);
    ticks(7);
    chk("R1 resumed count", tm, model(6130, 100, 60, 60, 24));
    clr_n = 1'b0;
    tick  = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R6 clear beats tick", tm, 32'h0);
    clr_n = 1'b1;
    ticks(15);
    chk("R6 clear stops the watch", tm, 32'h0);
  endtask

  task automatic t_press_in_clear();
    clr_n = 1'b0;
    repeat (2) @(negedge clk);
    btn = 1'b1;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    repeat (8) @(negedge clk);
    btn = 1'b0;
    repeat (4) @(negedge clk);
    ticks(20);
    chk("R7 press held through clear ignored", tm, 32'h0);
  endtask

  task automatic t_fast_day();
    int at = 0;
    int pts [8] = '{59, 60, 3599, 3600, 71999, 72000, 86399, 86400};
    repeat (3) @(negedge clk);
    clr2_n = 1'b1;
    btn2   = 1'b1;
    repeat (3) @(negedge clk);
    btn2 = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      ticks2(pts[k] - at);
      at = pts[k];
      chk(k < 4 ? "R2 fast chain carry" : "R3 hours wrap", tm2, model(at, 10, 6, 60, 24));
    end
  endtask

  initial begin
    t_reset();
    t_hold_idle();
    t_start_long_press();
    t_seconds_carry();
    t_stop_hold();
    t_display();
    t_clear_with_tick();
    t_press_in_clear();
    t_fast_day();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule